// File: doc/BRIEF.md
# Modem Control Line Monitor

This block looks after the four modem-control lines of one synchronous serial channel. Two of them are outputs: request-to-send and data-terminal-ready are driven low-active, so each pin carries the inverse of the control bit that software writes. The other two are inputs: carrier detect and clear-to-send arrive asynchronously from the line side. Each input passes through a two-flop synchroniser and then a minimum-width filter, so a short glitch never changes the level that the rest of the channel sees.

The filtered levels can be read as status bits. They also act as optional auto-enables. When carrier auto-enable is set, the receiver runs only while carrier detect is high. When clear-to-send auto-enable is set, the transmitter runs only while clear-to-send is high. When external/status interrupts are enabled, any accepted change on either filtered input sets a latched interrupt bit. That bit stays set until the processor issues a reset-status command.

Top module: `modem_line_monitor`

## Requirements
- R1: After reset, both filtered levels (`dcd_lvl`, `cts_lvl`) are 0 and `ext_irq` is 0.
- R2: `rts_n_o` always equals the inverse of `rts_bit`, and `dtr_n_o` always equals the inverse of `dtr_bit`.
- R3: Suppose an input changes just after a clock edge and then holds its new value. The matching filtered level takes the new value on the (MIN_WIDTH+2)-th rising edge that follows, and not earlier. Two of those edges belong to the synchroniser and MIN_WIDTH to the filter.
- R4: An input pulse lasting fewer than MIN_WIDTH clock cycles leaves the filtered level unchanged and does not set `ext_irq`.
- R5: With `ext_int_en` high, an accepted change of either filtered level sets `ext_irq` on the same edge on which the level changes. This holds for rising and falling changes on carrier detect and on clear-to-send alike.
- R6: With `ext_int_en` low, the filtered levels still follow the inputs, but `ext_irq` is never set.
- R7: Once set, `ext_irq` stays high until a cycle in which `clr_status` is high. On that edge `ext_irq` is cleared, unless a new accepted change arrives on the same edge, in which case `ext_irq` stays 1.
- R8: `rx_run` equals `rx_enable_req` when `dcd_auto_en` is 0. When `dcd_auto_en` is 1, `rx_run` equals `rx_enable_req` AND `dcd_lvl`.
- R9: `tx_run` equals `tx_enable_req` when `cts_auto_en` is 0. When `cts_auto_en` is 1, `tx_run` equals `tx_enable_req` AND `cts_lvl`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Channel clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rts_bit | input | 1 | Request-to-send control bit |
| dtr_bit | input | 1 | Data-terminal-ready control bit |
| rts_n_o | output | 1 | Request-to-send pin, inverse of its bit |
| dtr_n_o | output | 1 | Data-terminal-ready pin, inverse of its bit |
| dcd_i | input | 1 | Asynchronous carrier-detect input |
| cts_i | input | 1 | Asynchronous clear-to-send input |
| ext_int_en | input | 1 | Enables change monitoring for the interrupt |
| clr_status | input | 1 | Reset-status command pulse; clears the interrupt |
| dcd_auto_en | input | 1 | Gates the receiver with the carrier level |
| cts_auto_en | input | 1 | Gates the transmitter with the clear-to-send level |
| rx_enable_req | input | 1 | Receiver enable from the control register |
| tx_enable_req | input | 1 | Transmitter enable from the control register |
| rx_run | output | 1 | Effective receiver enable |
| tx_run | output | 1 | Effective transmitter enable |
| dcd_lvl | output | 1 | Filtered carrier-detect status |
| cts_lvl | output | 1 | Filtered clear-to-send status |
| ext_irq | output | 1 | Latched external/status interrupt |

## Verification
The bench times an accepted change to the exact edge. A filter that is off by one cycle, or that skips a synchroniser stage, moves the level change away from edge MIN_WIDTH+2. It sends a pulse one cycle shorter than the minimum width. A counter that fails to restart when the input returns would let this pulse through and raise a false interrupt. It places a new change on the same edge as a reset-status command. A latch that lets the clear win would lose that event. Finally, it changes the inputs while interrupts are disabled. The level must still follow, and a design that also gated the filter, or that left monitoring on, would show the wrong status or interrupt.

// File: rtl/modem_line_monitor.sv
module modem_line_monitor #(
  parameter int MIN_WIDTH   = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rts_bit,
  input  logic dtr_bit,
  output logic rts_n_o,
  output logic dtr_n_o,
  input  logic dcd_i,
  input  logic cts_i,
  input  logic ext_int_en,
  input  logic clr_status,
  input  logic dcd_auto_en,
  input  logic cts_auto_en,
  input  logic rx_enable_req,
  input  logic tx_enable_req,
  output logic rx_run,
  output logic tx_run,
  output logic dcd_lvl,
  output logic cts_lvl,
  output logic ext_irq
);

  localparam int CW = (MIN_WIDTH < 2) ? 1 : $clog2(MIN_WIDTH + 1);
  localparam logic [CW-1:0] LAST = CW'(MIN_WIDTH - 1);

  logic [1:0] raw, sync_out, lvl, flip;

  assign raw     = {cts_i, dcd_i};
  assign rts_n_o = ~rts_bit;
  assign dtr_n_o = ~dtr_bit;
  assign dcd_lvl = lvl[0];
  assign cts_lvl = lvl[1];
  assign rx_run  = rx_enable_req & (~dcd_auto_en | lvl[0]);
  assign tx_run  = tx_enable_req & (~cts_auto_en | lvl[1]);

  for (genvar i = 0; i < 2; i++) begin : g_line
    logic [SYNC_STAGES-1:0] sq;
    logic [CW-1:0]          cnt;

    assign sync_out[i] = sq[SYNC_STAGES-1];
    assign flip[i]     = (sync_out[i] != lvl[i]) && (cnt == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sq     <= '0;
        cnt    <= '0;
        lvl[i] <= 1'b0;
      end else begin
        sq <= {sq[SYNC_STAGES-2:0], raw[i]};
        if (sync_out[i] == lvl[i]) begin
          cnt <= '0;
        end else if (cnt == LAST) begin
          cnt    <= '0;
          lvl[i] <= sync_out[i];
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end

    AST_LVL_FROM_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(lvl[i]) |-> (lvl[i] == $past(sync_out[i])));  // R3
    AST_IRQ_ON_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(ext_int_en) && !$stable(lvl[i])) |-> ext_irq);  // R5
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  ext_irq <= 1'b0;
    else if (ext_int_en && |flip) ext_irq <= 1'b1;
    else if (clr_status)          ext_irq <= 1'b0;
  end

  AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_irq && !clr_status) |=> ext_irq);  // R7
  AST_IRQ_QUIET_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext_irq && !ext_int_en) |=> !ext_irq);  // R6
  AST_RX_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (dcd_auto_en && !dcd_lvl) |-> !rx_run);  // R8
  AST_TX_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (cts_auto_en && !cts_lvl) |-> !tx_run);  // R9

endmodule

// File: tb/modem_line_monitor_bench.sv
module modem_line_monitor_bench;
  localparam int MW = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic rts_bit = 0, dtr_bit = 0, dcd_i = 0, cts_i = 0;
  logic ext_int_en = 0, clr_status = 0, dcd_auto_en = 0, cts_auto_en = 0;
  logic rx_enable_req = 0, tx_enable_req = 0;
  logic rts_n_o, dtr_n_o, rx_run, tx_run, dcd_lvl, cts_lvl, ext_irq;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  modem_line_monitor #(.MIN_WIDTH(MW)) u_modem_line_monitor (
    .clk(clk), .rst_n(rst_n), .rts_bit(rts_bit), .dtr_bit(dtr_bit),
    .rts_n_o(rts_n_o), .dtr_n_o(dtr_n_o), .dcd_i(dcd_i), .cts_i(cts_i),
    .ext_int_en(ext_int_en), .clr_status(clr_status),
    .dcd_auto_en(dcd_auto_en), .cts_auto_en(cts_auto_en),
    .rx_enable_req(rx_enable_req), .tx_enable_req(tx_enable_req),
    .rx_run(rx_run), .tx_run(tx_run), .dcd_lvl(dcd_lvl), .cts_lvl(cts_lvl),
    .ext_irq(ext_irq));

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic clear_irq();
    clr_status = 1; cyc(1); clr_status = 0;
  endtask

  task automatic t_reset();
    chk("R1 dcd_lvl", dcd_lvl, 0);
    chk("R1 cts_lvl", cts_lvl, 0);
    chk("R1 ext_irq", ext_irq, 0);
  endtask

  task automatic t_outputs();
    for (int k = 0; k < 4; k++) begin
      rts_bit = k[0]; dtr_bit = k[1]; #1;
      chk("R2 rts_n_o", rts_n_o, ~k[0]);
      chk("R2 dtr_n_o", dtr_n_o, ~k[1]);
    end
    cyc(1);
  endtask

  task automatic t_timing();
    ext_int_en = 1;
    dcd_i = 1; cyc(MW + 1);
    chk("R3 dcd early", dcd_lvl, 0);
    chk("R5 irq early", ext_irq, 0);
    cyc(1);
    chk("R3 dcd on time", dcd_lvl, 1);
    chk("R5 irq dcd rise", ext_irq, 1);
    clear_irq();
    chk("R7 cleared", ext_irq, 0);
  endtask

  task automatic t_glitch();
    dcd_i = 0; cyc(MW - 1); dcd_i = 1; cyc(MW + 4);
    chk("R4 level kept", dcd_lvl, 1);
    chk("R4 no irq", ext_irq, 0);
    dcd_i = 0; cyc(MW + 2);
    chk("R3 dcd fall", dcd_lvl, 0);
    chk("R5 irq dcd fall", ext_irq, 1);
    cyc(5);
    chk("R7 irq held", ext_irq, 1);
    clear_irq();
  endtask

  task automatic t_cts_irq();
    cts_i = 1; cyc(MW + 2);
    chk("R5 cts rise lvl", cts_lvl, 1);
    chk("R5 cts rise irq", ext_irq, 1);
    clear_irq();
  endtask

  task automatic t_set_vs_clear();
    cts_i = 0; cyc(MW + 1);
    chk("R7 before", ext_irq, 0);
    clr_status = 1; cyc(1); clr_status = 0;
    chk("R7 set beats clear", ext_irq, 1);
    chk("R5 cts fall lvl", cts_lvl, 0);
    clear_irq();
  endtask

  task automatic t_disabled();
    ext_int_en = 0;
    dcd_i = 1; cts_i = 1; cyc(MW + 2);
    chk("R6 dcd tracks", dcd_lvl, 1);
    chk("R6 cts tracks", cts_lvl, 1);
    chk("R6 no irq", ext_irq, 0);
  endtask

  task automatic t_gates();
    rx_enable_req = 1; tx_enable_req = 1; dcd_auto_en = 1; cts_auto_en = 1; #1;
    chk("R8 rx on with carrier", rx_run, 1);
    chk("R9 tx on with cts", tx_run, 1);
    dcd_i = 0; cts_i = 0; cyc(MW + 2);
    chk("R8 rx gated", rx_run, 0);
    chk("R9 tx gated", tx_run, 0);
    dcd_auto_en = 0; cts_auto_en = 0; #1;
    chk("R8 rx ungated", rx_run, 1);
    chk("R9 tx ungated", tx_run, 1);
    rx_enable_req = 0; tx_enable_req = 0; #1;
    chk("R8 rx off", rx_run, 0);
    chk("R9 tx off", tx_run, 0);
  endtask

  initial begin
    cyc(2); rst_n = 1; cyc(1);
    t_reset();
    t_outputs();
    t_timing();
    t_glitch();
    t_cts_irq();
    t_set_vs_clear();
    t_disabled();
    t_gates();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule